// File: doc/BRIEF.md
# Misaligned Bus Transfer Sequencer

This block takes one operand access from a processor core (a byte, a 16-bit word or a 32-bit long word, at any byte address) and turns it into the aligned bus cycles that a 32-bit big-endian data bus can carry. Each bus cycle drives a byte address, a 2-bit size code and a write data word. In that write data word, every operand byte sits on the byte lane that its address selects. The block holds each cycle until the slave acknowledges it, and only then starts the next cycle. On reads, it picks the returned bytes off their lanes and assembles them into a right-justified operand.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While the block is busy, `req_ready` stays low and `req_valid` is ignored, so the requester must hold its request until it is taken. On the bus side, the slave applies back-pressure by keeping `bus_ack` low. Completion is reported with a single-cycle `done` strobe, and `done_rdata` carries the operand during that strobe.

Byte lane k carries bits 31-8k down to 24-8k. Lane 0 is bits 31:24 and is used by the lowest address of a long word. A parameter `MID_WORD_OK` lets a word at offset 1 go out as one word cycle on the middle lanes. When the parameter is 0 (the default), that word is sent as two byte cycles. Size code 11 on the request side is treated as a long word.

Top module: `mis_xfer_seq`

## Requirements
- R1: An aligned access finishes in one bus cycle of its own size. Aligned means a byte at any offset, a word at offset 0 or 2, or a long word at offset 0.
- R2: A long word at offset 1 or offset 3 takes three cycles, in this order: a byte cycle, then a word cycle, then a byte cycle.
- R3: A long word at offset 2 takes two word cycles.
- R4: With `MID_WORD_OK`=0, a word at offset 1 or offset 3 takes two byte cycles. No word cycle is ever issued at an odd address.
- R5: The address of each bus cycle equals the request address plus the number of operand bytes already moved. The operand's most significant byte is moved first, at the lowest address.
- R6: `bus_size` codes are 01 for a byte, 10 for a word and 00 for a long word. The code 11 never appears on the bus.
- R7: On writes, operand byte i (counted from the most significant byte) is placed on lane (cycle address mod 4) + (i − bytes already moved). Lanes that are not part of the cycle are driven as zero.
- R8: While `bus_ack` is low, `bus_valid` stays high and the address, size and write data of the current cycle do not change. The next cycle starts only after an acknowledge.
- R9: On reads, `done_rdata` holds the operand bytes taken from the acknowledged lanes, right-justified. The value driven on the lanes outside each cycle has no effect on the result.
- R10: `done` is high for exactly one clock, and that clock is the one after the final acknowledge. `req_ready` is high only while no bus cycle is pending. A request presented while the block is busy is not taken and does not change the bus cycles in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size: 01 byte, 10 word, 00 long word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| bus_valid | output | 1 | A bus cycle is in progress |
| bus_addr | output | ADDR_W | Byte address of the current cycle |
| bus_size | output | 2 | Size code of the current cycle |
| bus_write | output | 1 | Direction of the current cycle |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ack | input | 1 | Slave acknowledge for the current cycle |
| bus_rdata | input | 32 | Read data from the slave, sampled on acknowledge |
| done | output | 1 | One-clock completion strobe |
| done_rdata | output | 32 | Assembled read operand, valid while done is high |

## Verification
The bound checker watches four properties on every clock:
- A stalled cycle holds steady.
- No long-word cycle is issued off alignment, and no word cycle is issued at an odd address.
- The illegal size code never reaches the bus, and single-byte writes leave the unused lanes at zero.
- `done` always follows an acknowledge, and `req_ready` is never high while a cycle is pending.

Some behaviour can only be shown by the bench's scenarios. These are the exact order and count of cycles for each size and offset, the address and lane placement of every byte, the assembled read value when the unused lanes carry junk, and the rejection of a request while the block is stalled mid-sequence.

// File: rtl/mis_xfer_pkg.sv
package mis_xfer_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10
  } xfer_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;

  // Operand byte count for a request size code; code 11 maps to long word.
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/mis_xfer_planner.sv
// Chooses the width of the next bus cycle from the current offset and the
// number of operand bytes still to move.
module mis_xfer_planner
  import mis_xfer_pkg::*;
#(
  parameter bit MID_WORD_OK = 1'b0
) (
  input  logic [1:0]  offset,
  input  logic [2:0]  remain,
  output logic [2:0]  nbytes,
  output xfer_size_e  code
);
  always_comb begin
    nbytes = 3'd1;
    code   = SZ_BYTE;
    if (offset[0]) begin
      if (MID_WORD_OK && remain == 3'd2 && offset == 2'd1) begin
        nbytes = 3'd2;
        code   = SZ_WORD;
      end
    end else if (remain == 3'd4 && offset == 2'd0) begin
      nbytes = 3'd4;
      code   = SZ_LONG;
    end else if (remain >= 3'd2) begin
      nbytes = 3'd2;
      code   = SZ_WORD;
    end
  end
endmodule

// File: rtl/mis_xfer_lane_steer.sv
// Places the operand bytes of the current cycle onto their byte lanes.
module mis_xfer_lane_steer
  import mis_xfer_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  logic [2:0]        op_bytes,
  input  logic [2:0]        moved,
  input  logic [1:0]        offset,
  input  logic [2:0]        nbytes,
  output logic [DATA_W-1:0] lanes
);
  logic [3:0] op4, mv4, off4, nb4;
  assign op4  = {1'b0, op_bytes};
  assign mv4  = {1'b0, moved};
  assign off4 = {2'b00, offset};
  assign nb4  = {1'b0, nbytes};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [3:0] K = 4'(k);
    logic       hit;
    logic [3:0] idx;
    logic [3:0] sh;
    logic [7:0] lane_byte;
    always_comb begin
      hit       = (K >= off4) && (K < off4 + nb4);
      idx       = mv4 + K - off4;
      sh        = op4 - 4'd1 - idx;
      lane_byte = hit ? 8'(operand >> {sh[1:0], 3'b000}) : 8'h00;
    end
    assign lanes[8*(LANES-1-k) +: 8] = lane_byte;
  end
endmodule

// File: rtl/mis_xfer_gather.sv
// Collects read bytes from their lanes into a right-justified operand.
module mis_xfer_gather
  import mis_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [2:0]        op_bytes,
  input  logic [2:0]        moved,
  input  logic [1:0]        offset,
  input  logic [2:0]        nbytes,
  output logic [DATA_W-1:0] operand
);
  logic [3:0] op4, mv4, off4, nb4;
  assign op4  = {1'b0, op_bytes};
  assign mv4  = {1'b0, moved};
  assign off4 = {2'b00, offset};
  assign nb4  = {1'b0, nbytes};

  for (genvar p = 0; p < LANES; p++) begin : g_byte
    localparam logic [3:0] P = 4'(p);
    logic       take;
    logic [3:0] idx;
    logic [3:0] lane4;
    logic [7:0] sel;
    logic [7:0] held;
    always_comb begin
      idx   = op4 - 4'd1 - P;
      take  = capture && (P < op4) && (idx >= mv4) && (idx < mv4 + nb4);
      lane4 = off4 + idx - mv4;
      sel   = 8'(bus_rdata >> {~lane4[1:0], 3'b000});
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clear) held <= 8'h00;
      else if (take)       held <= sel;
    end
    assign operand[8*p +: 8] = held;
  end
endmodule

// File: rtl/mis_xfer_seq.sv
module mis_xfer_seq
  import mis_xfer_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter bit MID_WORD_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              done,
  output logic [31:0]       done_rdata
);
  seq_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        remain, moved, op_bytes, nbytes;
  logic [DATA_W-1:0] op_wdata, steered;
  logic              is_write, done_q, accept, step, last;
  xfer_size_e        code;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign step      = (state == ST_BUSY) && bus_ack;
  assign last      = (remain == nbytes);

  mis_xfer_planner #(.MID_WORD_OK(MID_WORD_OK)) planner_i (
    .offset (cur_addr[1:0]),
    .remain (remain),
    .nbytes (nbytes),
    .code   (code)
  );

  mis_xfer_lane_steer steer_i (
    .operand  (op_wdata),
    .op_bytes (op_bytes),
    .moved    (moved),
    .offset   (cur_addr[1:0]),
    .nbytes   (nbytes),
    .lanes    (steered)
  );

  mis_xfer_gather gather_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .capture   (step && !is_write),
    .bus_rdata (bus_rdata),
    .op_bytes  (op_bytes),
    .moved     (moved),
    .offset    (cur_addr[1:0]),
    .nbytes    (nbytes),
    .operand   (done_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      remain   <= 3'd0;
      moved    <= 3'd0;
      op_bytes <= 3'd0;
      op_wdata <= '0;
      is_write <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state    <= ST_BUSY;
        cur_addr <= req_addr;
        op_bytes <= size_to_bytes(req_size);
        remain   <= size_to_bytes(req_size);
        moved    <= 3'd0;
        op_wdata <= req_wdata;
        is_write <= req_write;
      end else if (step) begin
        cur_addr <= cur_addr + ADDR_W'(nbytes);
        moved    <= moved + nbytes;
        remain   <= remain - nbytes;
        if (last) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign bus_valid = (state == ST_BUSY);
  assign bus_addr  = cur_addr;
  assign bus_size  = code;
  assign bus_write = is_write;
  assign bus_wdata = is_write ? steered : '0;
  assign done      = done_q;
endmodule

// File: rtl/mis_xfer_seq_chk.sv
module mis_xfer_seq_chk #(
  parameter int ADDR_W      = 32,
  parameter bit MID_WORD_OK = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_write,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              done
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata)); // R8
  AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size == 2'b00 |-> bus_addr[1:0] == 2'b00); // R1
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size == 2'b10 && !MID_WORD_OK |-> !bus_addr[0]); // R4
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_size != 2'b11); // R6
  AST_BYTE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_size == 2'b01 |->
      (bus_wdata & ~(32'hFF00_0000 >> {bus_addr[1:0], 3'b000})) == 32'h0); // R7
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_valid && bus_ack)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid); // R10
endmodule

bind mis_xfer_seq mis_xfer_seq_chk #(.ADDR_W(ADDR_W), .MID_WORD_OK(MID_WORD_OK)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_write (bus_write),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .done      (done)
);

// File: tb/mis_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module mis_xfer_seq_tb_top;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = 2'b00;
  logic              req_write = 1'b0;
  logic [31:0]       req_wdata = '0;
  logic              bus_valid;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic              bus_write;
  logic [31:0]       bus_wdata;
  logic              bus_ack = 1'b0;
  logic [31:0]       bus_rdata = '0;
  logic              done;
  logic [31:0]       done_rdata;

  always #4 clk = ~clk;

  mis_xfer_seq #(.ADDR_W(ADDR_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [64];

  // Reference model state
  int          q_n[$];
  int          m_busy = 0, m_idx = 0, m_moved = 0, m_bytes = 0, m_wr = 0, m_done = 0;
  logic [31:0] m_addr = 0, m_wdata = 0, m_rexp = 0;
  string       m_tag = "R1";
  logic        hold_ack = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle widths per size/offset, written out from the requirements.
  task automatic plan(input int nb, input int off);
    q_n.delete();
    if (nb == 1) q_n.push_back(1);
    else if (nb == 2) begin
      if (off % 2 == 0) q_n.push_back(2);
      else begin q_n.push_back(1); q_n.push_back(1); end
    end else begin
      case (off)
        0: q_n.push_back(4);
        2: begin q_n.push_back(2); q_n.push_back(2); end
        default: begin q_n.push_back(1); q_n.push_back(2); q_n.push_back(1); end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (req_valid) begin
          m_busy  = 1; m_idx = 0; m_moved = 0;
          m_addr  = req_addr; m_wdata = req_wdata; m_wr = req_write;
          m_bytes = (req_size == 2'b01) ? 1 : (req_size == 2'b10) ? 2 : 4;
          plan(m_bytes, int'(req_addr[1:0]));
          if (m_bytes == 4 && req_addr[0]) m_tag = "R2";
          else if (m_bytes == 4 && req_addr[1:0] == 2) m_tag = "R3";
          else if (m_bytes == 2 && req_addr[0]) m_tag = "R4";
          else m_tag = "R1";
          m_rexp = 0;
          for (int i = 0; i < m_bytes; i++)
            m_rexp = (m_rexp << 8) | 32'(mem[(m_addr + 32'(i)) % 64]);
        end
      end else if (bus_ack) begin
        m_moved += q_n[m_idx];
        m_idx++;
        if (m_idx == q_n.size()) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ca, ew, rd;
      int n, lo;
      chk(32'(req_ready), 32'(m_busy == 0), "R10 req_ready");
      chk(32'(bus_valid), 32'(m_busy), "R8 bus_valid");
      chk(32'(done), 32'(m_done), "R10 done strobe");
      if (m_done && m_wr == 0) chk(done_rdata, m_rexp, "R9 read operand");
      rd = 32'hEEEE_EEEE;
      if (m_busy) begin
        ca = m_addr + 32'(m_moved);
        n  = q_n[m_idx];
        lo = int'(ca[1:0]);
        chk(bus_addr, ca, "R5 cycle address");
        chk(32'(bus_size), (n == 1) ? 32'd1 : (n == 2) ? 32'd2 : 32'd0, {m_tag, " R6 size"});
        chk(32'(bus_write), 32'(m_wr), "R8 direction");
        ew = 0;
        for (int L = 0; L < 4; L++) begin
          if (L >= lo && L < lo + n) begin
            ew[8*(3-L) +: 8] = 8'(m_wdata >> (8 * (m_bytes - 1 - (m_moved + L - lo))));
            rd[8*(3-L) +: 8] = mem[((ca - 32'(lo)) + 32'(L)) % 64];
          end
        end
        if (m_wr != 0) chk(bus_wdata, ew, "R7 write lanes");
      end
      bus_rdata = rd;
      bus_ack   = (m_busy != 0) && !hold_ack && ($urandom % 3 != 0);
    end
  end

  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                       input logic [31:0] wd, input bit intr);
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (intr) begin
      // R10: a request while stalled mid-sequence must be rejected
      hold_ack = 1'b1;
      req_addr = 32'h3C; req_size = 2'b01; req_write = ~wr; req_wdata = 32'h5A5A_5A5A;
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      hold_ack = 1'b0;
    end
    while (m_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(32'(req_ready), 32'd1, "R10 reset ready");
    chk(32'(bus_valid), 32'd0, "R8 reset bus_valid");
    chk(32'(done), 32'd0, "R10 reset done");
    rst_n = 1'b1;
    for (int rep = 0; rep < 3; rep++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int s = 0; s < 3; s++) begin
          for (int off = 0; off < 4; off++) begin
            logic [1:0] sc;
            sc = (s == 0) ? 2'b01 : (s == 1) ? 2'b10 : 2'b00;
            issue(32'(16 * (rep + 1) + off + 8 * s), sc, wr[0], $urandom,
                  (s == 2 && off != 0));
          end
        end
      end
    end
    // Illegal size code behaves as a long word at an odd address (R2)
    issue(32'h21, 2'b11, 1'b0, 32'h0, 1'b0);
    issue(32'h23, 2'b11, 1'b1, 32'hA1B2_C3D4, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule